// File: doc/BRIEF.md
# Half-Duplex SPI Command Engine

This block is a memory-mapped SPI master that runs one flash-style command each time software triggers it. Software sets an 8-bit opcode, places the bytes to transmit in a byte-addressed data buffer, and programs a transmit count and a receive count. It then picks one of four chip-select outputs and sets an execute bit. The engine drops the chosen chip select and shifts out the opcode, then the transmit bytes from the buffer. It then clocks in the receive bytes and stores them in the same buffer, directly after the transmitted bytes.

The engine uses a single internal buffer pointer. A command starts reading transmit bytes at the pointer and leaves the pointer just past its last received byte. A self-clearing control bit rewinds the pointer to zero. Software polls a busy flag that covers the whole command and can also use a sticky done flag. The serial side runs SPI mode 0, MSB first, with SCLK at a fixed quarter of the system clock.

Top module: `spicmd_engine`

## Requirements
- R1: After reset every chip-select output is high, SCLK and MOSI are low, and the registers and the status byte read 0.
- R2: The byte registers are: opcode at 0x00, control at 0x02 (bit 0 execute, bit 4 buffer clear, both self-clearing and read as 0), busy at 0x03 (bit 7), chip-select select at 0x1D (bits 1:0), transmit count at 0x48, receive count at 0x4B, status at 0x4C (bit 0 busy, bit 1 done). The buffer is at 0x80 to 0x80+DEPTH-1.
- R3: A command with n = 1 + effective transmit bytes + effective receive bytes keeps the selected chip select low for DIV lead cycles, then 8·n bit periods of DIV cycles each, then DIV trailing cycles. SCLK is low in the first half of each bit period, high in the second half, and low outside the bit periods.
- R4: MOSI changes only while SCLK is low and carries the opcode first, then the transmit bytes read from the buffer starting at the pointer, each byte MSB first.
- R5: MISO is sampled while SCLK is high. Received byte i is stored MSB first at buffer offset start pointer + effective transmit count + i.
- R6: MISO is ignored during the opcode and transmit bytes, and the transmit bytes in the buffer are unchanged. MOSI is low during receive bytes.
- R7: Busy is 1 from the clock edge that takes the execute write until the trailing period ends. An execute write while busy is ignored.
- R8: While busy, bus writes to the opcode, counts, chip-select select, control and buffer are ignored.
- R9: A command leaves the pointer at start + effective transmit + effective receive, and the next command starts there. A buffer-clear write resets the pointer to 0, and a clear together with execute in one write clears the pointer first.
- R10: Effective transmit = min(transmit count, DEPTH − start) and effective receive = min(receive count, DEPTH − start − effective transmit).
- R11: Done is set when a command ends and stays set until software writes 1 to status bit 1. If the set and the clear happen in the same cycle, the set wins.
- R12: Only the chip select chosen by the select field goes low, and no chip select goes low while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 8 | Register bus byte address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational from bus_addr) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
On every cycle the assertions check these properties. At most one chip select is low, and SCLK never toggles with all selects high. The chip selects hold steady for the whole command, and MOSI holds while SCLK is high. Received bytes are only ever written past the transmit region. Execute and clear pulses reach the sequencer only when it is idle, and the pointer stays within the buffer. The bench compares the serial pins cycle by cycle against a behavioural model. Only its scenarios can show where received data lands in the buffer. They also show that the pointer carries over from one command to the next, that counts are truncated at the buffer end, and that writes during a command leave the registers and buffer untouched.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} seq_state_t;

  localparam logic [7:0] A_OPCODE = 8'h00;
  localparam logic [7:0] A_CTRL   = 8'h02;
  localparam logic [7:0] A_BUSY   = 8'h03;
  localparam logic [7:0] A_CSSEL  = 8'h1D;
  localparam logic [7:0] A_TXCNT  = 8'h48;
  localparam logic [7:0] A_RXCNT  = 8'h4B;
  localparam logic [7:0] A_STATUS = 8'h4C;
  localparam logic [7:0] A_BUF    = 8'h80;

  // transmit bytes that fit between the start pointer and the buffer end
  function automatic int unsigned clamp_tx(int unsigned req, int unsigned start,
                                           int unsigned depth);
    int unsigned room;
    room = depth - start;
    return (req > room) ? room : req;
  endfunction

  // receive bytes that fit after the transmit bytes
  function automatic int unsigned clamp_rx(int unsigned req, int unsigned start,
                                           int unsigned txe, int unsigned depth);
    int unsigned room;
    room = depth - start - txe;
    return (req > room) ? room : req;
  endfunction

endpackage

// File: rtl/spicmd_buf.sv
module spicmd_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [7:0]    eng_wdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [7:0]    eng_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (eng_we) begin
      mem[eng_waddr] <= eng_wdata;
    end else if (bus_we) begin
      mem[bus_addr] <= bus_wdata;
    end
  end

  assign bus_rdata = mem[bus_addr];
  assign eng_rdata = mem[eng_raddr];

  // bus writes are blocked during a command, so the two write ports never meet
  assert_no_port_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> !bus_we);
endmodule

// File: rtl/spicmd_regs.sv
module spicmd_regs
  import spicmd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int NCS   = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(NCS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          busy_i,
  input  logic          done_set_i,
  input  logic [7:0]    buf_rdata_i,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [7:0]    opcode_o,
  output logic [SW-1:0] cssel_o,
  output logic [7:0]    txcnt_o,
  output logic [7:0]    rxcnt_o,
  output logic          exec_o,
  output logic          clr_o
);
  logic done_q;
  logic wr_ok;
  logic buf_hit;

  assign wr_ok   = bus_wr && !busy_i;
  assign buf_hit = ({1'b0, bus_addr} >= {1'b0, A_BUF}) &&
                   ({1'b0, bus_addr} < (9'(A_BUF) + 9'(DEPTH)));
  assign buf_addr_o = AW'(bus_addr - A_BUF);
  assign buf_we_o   = wr_ok && buf_hit;
  assign exec_o     = wr_ok && (bus_addr == A_CTRL) && bus_wdata[0];
  assign clr_o      = wr_ok && (bus_addr == A_CTRL) && bus_wdata[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_o <= '0;
      cssel_o  <= '0;
      txcnt_o  <= '0;
      rxcnt_o  <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        A_OPCODE: opcode_o <= bus_wdata;
        A_CSSEL:  cssel_o  <= bus_wdata[SW-1:0];
        A_TXCNT:  txcnt_o  <= bus_wdata;
        A_RXCNT:  rxcnt_o  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else if (done_set_i) done_q <= 1'b1;
    else if (bus_wr && bus_addr == A_STATUS && bus_wdata[1]) done_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      A_OPCODE: bus_rdata = opcode_o;
      A_BUSY:   bus_rdata = {busy_i, 7'b0};
      A_CSSEL:  bus_rdata = 8'(cssel_o);
      A_TXCNT:  bus_rdata = txcnt_o;
      A_RXCNT:  bus_rdata = rxcnt_o;
      A_STATUS: bus_rdata = {6'b0, done_q, busy_i};
      default:  bus_rdata = buf_hit ? buf_rdata_i : 8'h00;
    endcase
  end

  assert_done_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_set_i |=> done_q);
  assert_done_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STATUS && bus_wdata[1] && !done_set_i) |=> !done_q);
endmodule

// File: rtl/spicmd_shift.sv
module spicmd_shift #(
  parameter int DIV = 4,
  localparam int QW = (DIV > 2) ? $clog2(DIV) : 1,
  localparam int HALF = DIV / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  input  logic       txen_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       byte_end_o,
  output logic [7:0] rx_byte_o
);
  logic [QW-1:0] q;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          smp;
  logic          last_q;

  assign last_q = (q == QW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0; bitn <= '0; sh <= '0; smp <= 1'b0;
    end else begin
      if (run_i) begin
        q <= last_q ? '0 : q + 1'b1;
        if (q == QW'(HALF)) smp <= miso_i;
        if (last_q) bitn <= bitn + 1'b1;
      end else begin
        q <= '0;
        bitn <= '0;
      end
      if (load_i) sh <= load_data_i;
      else if (run_i && last_q) sh <= {sh[6:0], smp};
    end
  end

  assign sclk_o     = run_i && (q >= QW'(HALF));
  assign mosi_o     = run_i && txen_i && sh[7];
  assign byte_end_o = run_i && last_q && (bitn == 3'd7);
  assign rx_byte_o  = {sh[6:0], smp};

  // mode 0: data must hold while the clock is high
  assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(mosi_o));
endmodule

// File: rtl/spicmd_seq.sv
module spicmd_seq
  import spicmd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DIV   = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1),
  localparam int KW = PW + 1,
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_i,
  input  logic          clr_i,
  input  logic [7:0]    opcode_i,
  input  logic [7:0]    txcnt_i,
  input  logic [7:0]    rxcnt_i,
  input  logic          byte_end_i,
  input  logic [7:0]    rx_byte_i,
  input  logic [7:0]    buf_rdata_i,
  output logic [AW-1:0] buf_raddr_o,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_waddr_o,
  output logic [7:0]    buf_wdata_o,
  output logic          busy_o,
  output logic          run_o,
  output logic          load_o,
  output logic [7:0]    load_data_o,
  output logic          txen_o,
  output logic          done_o
);
  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic [PW-1:0] ptr, txe, p0, txe_n, rxe_n;
  logic [KW-1:0] k, last_k, next_k;
  logic          cur_rx, next_is_tx, cnt_end, last_byte;

  assign p0    = clr_i ? '0 : ptr;
  assign txe_n = PW'(clamp_tx(int'(txcnt_i), int'(p0), DEPTH));
  assign rxe_n = PW'(clamp_rx(int'(rxcnt_i), int'(p0), int'(txe_n), DEPTH));

  assign cnt_end    = (cnt == CW'(DIV - 1));
  assign next_k     = k + 1'b1;
  assign next_is_tx = (next_k <= {1'b0, txe});
  assign last_byte  = (k == last_k);

  assign busy_o      = (state != ST_IDLE);
  assign run_o       = (state == ST_SHIFT);
  assign txen_o      = !cur_rx;
  assign done_o      = (state == ST_TRAIL) && cnt_end;
  assign buf_raddr_o = ptr[AW-1:0];
  assign buf_we_o    = run_o && byte_end_i && cur_rx;
  assign buf_waddr_o = ptr[AW-1:0];
  assign buf_wdata_o = rx_byte_i;
  assign load_o      = ((state == ST_LEAD) && cnt_end) ||
                       (run_o && byte_end_i && !last_byte);
  assign load_data_o = (state == ST_LEAD) ? opcode_i :
                       (next_is_tx ? buf_rdata_i : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; ptr <= '0; txe <= '0;
      k <= '0; last_k <= '0; cur_rx <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (exec_i) begin
            ptr    <= p0;
            txe    <= txe_n;
            last_k <= KW'(txe_n) + KW'(rxe_n);
            k      <= '0;
            cnt    <= '0;
            cur_rx <= 1'b0;
            state  <= ST_LEAD;
          end else if (clr_i) begin
            ptr <= '0;
          end
        end
        ST_LEAD: begin
          cnt <= cnt + 1'b1;
          if (cnt_end) begin
            cnt   <= '0;
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (byte_end_i) begin
            if (cur_rx) ptr <= ptr + 1'b1;
            if (last_byte) begin
              state <= ST_TRAIL;
            end else begin
              k <= next_k;
              if (next_is_tx) begin
                ptr    <= ptr + 1'b1;
                cur_rx <= 1'b0;
              end else begin
                cur_rx <= 1'b1;
              end
            end
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt_end) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assert_exec_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |-> state == ST_IDLE);
  assert_clr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> state == ST_IDLE);
  assert_ptr_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(DEPTH));
  assert_rx_after_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_o |-> k > {1'b0, txe});
endmodule

// File: rtl/spicmd_engine.sv
module spicmd_engine #(
  parameter int DEPTH = 64,
  parameter int DIV   = 4,
  parameter int NCS   = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  output logic           spi_sclk,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs_n
);
  logic          busy, done_set, exec, clr;
  logic          bbuf_we, ebuf_we;
  logic [AW-1:0] bbuf_addr, ebuf_raddr, ebuf_waddr;
  logic [7:0]    bbuf_rdata, ebuf_rdata, ebuf_wdata;
  logic [7:0]    opcode, txcnt, rxcnt;
  logic [SW-1:0] cssel;
  logic          run, load, txen, byte_end;
  logic [7:0]    load_data, rx_byte;

  spicmd_regs #(.DEPTH(DEPTH), .NCS(NCS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_i(busy),
    .done_set_i(done_set), .buf_rdata_i(bbuf_rdata), .buf_we_o(bbuf_we),
    .buf_addr_o(bbuf_addr), .opcode_o(opcode), .cssel_o(cssel),
    .txcnt_o(txcnt), .rxcnt_o(rxcnt), .exec_o(exec), .clr_o(clr));

  spicmd_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .bus_we(bbuf_we), .bus_addr(bbuf_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bbuf_rdata), .eng_we(ebuf_we),
    .eng_waddr(ebuf_waddr), .eng_wdata(ebuf_wdata), .eng_raddr(ebuf_raddr),
    .eng_rdata(ebuf_rdata));

  spicmd_seq #(.DEPTH(DEPTH), .DIV(DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .exec_i(exec), .clr_i(clr), .opcode_i(opcode),
    .txcnt_i(txcnt), .rxcnt_i(rxcnt), .byte_end_i(byte_end),
    .rx_byte_i(rx_byte), .buf_rdata_i(ebuf_rdata), .buf_raddr_o(ebuf_raddr),
    .buf_we_o(ebuf_we), .buf_waddr_o(ebuf_waddr), .buf_wdata_o(ebuf_wdata),
    .busy_o(busy), .run_o(run), .load_o(load), .load_data_o(load_data),
    .txen_o(txen), .done_o(done_set));

  spicmd_shift #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .run_i(run), .load_i(load),
    .load_data_i(load_data), .txen_i(txen), .miso_i(spi_miso),
    .sclk_o(spi_sclk), .mosi_o(spi_mosi), .byte_end_o(byte_end),
    .rx_byte_o(rx_byte));

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign spi_cs_n[g] = !(busy && (cssel == SW'(g)));
  end

  assert_one_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  assert_sclk_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> (spi_cs_n != {NCS{1'b1}}));
  assert_cs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_cs_n));
endmodule

// File: tb/spicmd_engine_test.sv
`timescale 1ns/1ps
module spicmd_engine_test;
  localparam int DEPTH = 64;
  localparam int DIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  wire  [7:0] bus_rdata;
  wire        spi_sclk, spi_mosi;
  logic       spi_miso = 1'b0;
  wire  [3:0] spi_cs_n;

  spicmd_engine #(.DEPTH(DEPTH), .DIV(DIV), .NCS(4)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int checks = 0, bad = 0;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_buf[DEPTH];
  int m_op, m_sel, m_tx, m_rx, m_ptr, m_done;
  int t = -1;
  int m_len, m_txe, m_rxe, m_rxbase;
  int m_bytes[$];
  int slave_rx[$];
  int falls = 0;
  logic prev_sclk = 1'b0;
  int cs_cycles = 0;
  int cyc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_buf[i] = 0;
      m_op = 0; m_sel = 0; m_tx = 0; m_rx = 0; m_ptr = 0; m_done = 0; t = -1;
    end else begin
      bit busy_m;
      int p0, a;
      busy_m = (t >= 0);
      if (bus_wr && bus_addr == 8'h4C && bus_wdata[1]) m_done = 0;
      if (busy_m) begin
        t++;
        if (t == m_len) begin
          t = -1;
          for (int i = 0; i < m_rxe; i++)
            m_buf[m_rxbase + i] = (i < slave_rx.size()) ? slave_rx[i] : 0;
          m_done = 1;
        end
      end
      if (bus_wr && !busy_m) begin
        a = bus_addr;
        if (a == 8'h00) m_op = bus_wdata;
        if (a == 8'h1D) m_sel = bus_wdata & 3;
        if (a == 8'h48) m_tx = bus_wdata;
        if (a == 8'h4B) m_rx = bus_wdata;
        if (a >= 8'h80 && a < 8'h80 + DEPTH) m_buf[a - 8'h80] = bus_wdata;
        if (a == 8'h02) begin
          if (bus_wdata[4]) m_ptr = 0;
          if (bus_wdata[0]) begin
            p0 = m_ptr;
            m_txe = (m_tx > DEPTH - p0) ? DEPTH - p0 : m_tx;
            m_rxe = (m_rx > DEPTH - p0 - m_txe) ? DEPTH - p0 - m_txe : m_rx;
            m_bytes.delete();
            m_bytes.push_back(m_op);
            for (int i = 0; i < m_txe; i++) m_bytes.push_back(m_buf[p0 + i]);
            m_rxbase = p0 + m_txe;
            m_ptr = p0 + m_txe + m_rxe;
            m_len = 2 * DIV + 8 * DIV * (1 + m_txe + m_rxe);
            falls = 0;
            t = 0;
          end
        end
      end
    end
  end

  // per-cycle comparison of the serial pins and the slave model
  always @(negedge clk) begin
    if (rst_n) begin
      int ecs, es, em, u, bi, by, b, rxi;
      ecs = 4'hF; es = 0; em = 0;
      if (t >= 0) begin
        ecs = (~(1 << m_sel)) & 4'hF;
        if (t >= DIV && t < m_len - DIV) begin
          u = t - DIV; bi = u / DIV; by = bi / 8;
          es = ((u % DIV) >= DIV / 2) ? 1 : 0;
          if (by < 1 + m_txe) em = (m_bytes[by] >> (7 - bi % 8)) & 1;
        end
      end
      check("R12", spi_cs_n, ecs, "cs_n per cycle");
      check("R3", spi_sclk, es, "sclk per cycle");
      check("R4", spi_mosi, em, "mosi per cycle (R6 when receiving)");
      if (spi_cs_n != 4'hF) cs_cycles++;
      if (prev_sclk && !spi_sclk) falls++;
      prev_sclk = spi_sclk;
      if (t >= 0) begin
        b = falls; by = b / 8;
        if (by < 1 + m_txe) spi_miso = (b % 3 == 1);
        else begin
          rxi = by - 1 - m_txe;
          spi_miso = (rxi < slave_rx.size()) ? ((slave_rx[rxi] >> (7 - b % 8)) & 1) : 1'b0;
        end
      end else spi_miso = 1'b1;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk); bus_wr = 1'b0; bus_addr = a;
    #0.5; v = bus_rdata;
  endtask

  task automatic rdchk(input logic [7:0] a, input int exp, input string req, input string what);
    int v;
    rd(a, v);
    check(req, v, exp, what);
  endtask

  task automatic wait_idle();
    int v;
    do rd(8'h4C, v); while (v & 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int mark, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", spi_cs_n, 4'hF, "cs_n after reset");
    check("R1", spi_sclk, 0, "sclk after reset");
    check("R1", spi_mosi, 0, "mosi after reset");
    rdchk(8'h4C, 0, "R1", "status after reset");
    rdchk(8'h00, 0, "R1", "opcode after reset");

    // R2 register readback
    wr(8'h00, 8'h9F); wr(8'h1D, 8'h06); wr(8'h48, 8'h00); wr(8'h4B, 8'h03);
    rdchk(8'h00, 8'h9F, "R2", "opcode readback");
    rdchk(8'h1D, 8'h02, "R2", "select field readback");
    rdchk(8'h4B, 8'h03, "R2", "rx count readback");
    rdchk(8'h02, 8'h00, "R2", "control reads 0");

    // command A: opcode then 3 receive bytes on select 2
    slave_rx = '{8'hA5, 8'h3C, 8'hF0};
    mark = cs_cycles;
    wr(8'h02, 8'h01);
    rdchk(8'h4C, 8'h01, "R7", "status busy mid command");
    rdchk(8'h03, 8'h80, "R2", "busy bit 7");
    wr(8'h02, 8'h01);          // R7: ignored while busy
    wr(8'h00, 8'h11);          // R8: ignored
    wr(8'h85, 8'h77);          // R8: ignored
    wr(8'h1D, 8'h03);          // R8: ignored
    wait_idle();
    check("R3", cs_cycles - mark, 2 * DIV + 8 * DIV * 4, "cs low cycles cmd A");
    rdchk(8'h4C, 8'h02, "R11", "done set after command");
    rdchk(8'h00, 8'h9F, "R8", "opcode kept");
    rdchk(8'h1D, 8'h02, "R8", "select kept");
    rdchk(8'h85, 8'h00, "R8", "buffer write ignored");
    rdchk(8'h80, 8'hA5, "R5", "rx byte 0");
    rdchk(8'h81, 8'h3C, "R5", "rx byte 1");
    rdchk(8'h82, 8'hF0, "R5", "rx byte 2");
    wr(8'h4C, 8'h02);
    rdchk(8'h4C, 8'h00, "R11", "done cleared by w1c");

    // command B: clear, 3 tx bytes, 2 rx bytes on select 1
    wr(8'h02, 8'h10);
    wr(8'h80, 8'h12); wr(8'h81, 8'h34); wr(8'h82, 8'h56);
    wr(8'h48, 8'h03); wr(8'h4B, 8'h02); wr(8'h1D, 8'h01); wr(8'h00, 8'h03);
    slave_rx = '{8'h81, 8'h7E};
    mark = cs_cycles;
    wr(8'h02, 8'h01);
    wait_idle();
    check("R3", cs_cycles - mark, 2 * DIV + 8 * DIV * 6, "cs low cycles cmd B");
    rdchk(8'h80, 8'h12, "R6", "tx byte 0 kept");
    rdchk(8'h81, 8'h34, "R6", "tx byte 1 kept");
    rdchk(8'h82, 8'h56, "R6", "tx byte 2 kept");
    rdchk(8'h83, 8'h81, "R5", "rx after tx 0");
    rdchk(8'h84, 8'h7E, "R5", "rx after tx 1");

    // R9: no clear, pointer continues at 5
    wr(8'h48, 8'h00); wr(8'h4B, 8'h02);
    slave_rx = '{8'hC3, 8'h5A};
    wr(8'h02, 8'h01);
    wait_idle();
    rdchk(8'h85, 8'hC3, "R9", "pointer carried over 0");
    rdchk(8'h86, 8'h5A, "R9", "pointer carried over 1");

    // R9: clear and execute in one write
    wr(8'h4B, 8'h01);
    slave_rx = '{8'h99};
    wr(8'h02, 8'h11);
    wait_idle();
    rdchk(8'h80, 8'h99, "R9", "clear before execute");
    rdchk(8'h81, 8'h34, "R9", "next byte untouched");

    // R10: truncation at buffer end
    wr(8'h02, 8'h10);
    for (int i = 0; i < 62; i++) wr(8'(8'h80 + i), 8'(i ^ 8'h40));
    wr(8'h48, 8'd62); wr(8'h4B, 8'd10); wr(8'h1D, 8'h00);
    slave_rx = '{8'hDE, 8'hAD, 8'hBE};
    mark = cs_cycles;
    wr(8'h02, 8'h01);
    wait_idle();
    check("R10", cs_cycles - mark, 2 * DIV + 8 * DIV * 65, "cs low cycles truncated");
    rdchk(8'hBD, 61 ^ 8'h40, "R10", "last tx byte kept");
    rdchk(8'hBE, 8'hDE, "R10", "rx at slot 62");
    rdchk(8'hBF, 8'hAD, "R10", "rx at slot 63");

    // R10: pointer at the end, only the opcode goes out
    wr(8'h48, 8'd5); wr(8'h4B, 8'd5);
    mark = cs_cycles;
    wr(8'h02, 8'h01);
    wait_idle();
    check("R10", cs_cycles - mark, 2 * DIV + 8 * DIV, "cs low cycles opcode only");
    rdchk(8'h80, 8'h40, "R10", "buffer start untouched");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule